// File: doc/BRIEF.md
# Learning Lookup Table with Per-Entry Status Flags

This block is a small binary content-addressable memory meant to hold the address table of a layer-2 switch. Every slot stores one key together with four status flags: a free marker, a skip marker that hides the slot, a pin marker that makes the slot immune to eviction, and a recently-used marker. A search presents a key and, one cycle later, reports whether some visible slot holds that key and, if so, the lowest such slot index. A hit also sets the recently-used marker of the slot that was reported.

A separate command port does the management. It can learn a key into the lowest free slot, either as an ordinary slot or as a pinned one. It can clear every recently-used marker to start an aging interval, or purge every occupied slot that has not been used since then and is not pinned. It can also set or clear the skip marker of one slot, or clear all skip markers. Software steps through several matching slots by skipping each reported hit and searching again. Searches always take precedence. A command presented in the same cycle as a search is held off through `cmd_rdy` and has no effect.

Top module: `cam_age_table`

## Requirements
- R1: After a synchronous reset every slot is free with all other flags clear, and `res_vld`, `res_hit`, `res_idx`, `cmd_done`, `cmd_full` and `cmd_slot` are all zero.
- R2: `res_vld` is high exactly in the cycle after a cycle with `srch_vld` high. When `res_vld` is low, `res_hit` and `res_idx` are zero, and on a miss `res_idx` is zero.
- R3: A free slot never produces a hit, whatever key it last held.
- R4: A slot whose skip marker is set never produces a hit. Clearing the marker makes it visible again.
- R5: When several visible slots hold the searched key, `res_idx` reports the lowest index among them.
- R6: A hit sets the recently-used marker of the reported slot in the same edge that registers the result.
- R7: Op 0 (learn) and op 1 (learn pinned) write `cmd_key` into the lowest slot that is free and not skipped. The slot is marked occupied and recently used, and pinned only for op 1. `cmd_slot` reports that index alongside `cmd_done`.
- R8: A learn that finds no slot that is free and not skipped raises `cmd_full` with `cmd_done`, reports `cmd_slot` zero, and changes no slot.
- R9: Op 2 clears the recently-used marker of every slot.
- R10: Op 3 (purge) frees every occupied slot that is neither recently used nor pinned, and leaves every other slot as it was.
- R11: Op 4 sets and op 5 clears the skip marker of slot `cmd_idx`, and op 6 clears all skip markers. The skip marker also applies to free slots, so a skipped free slot is held back from learning.
- R12: `cmd_rdy` equals the inverse of `srch_vld`. A command is carried out only when `cmd_vld` and `cmd_rdy` are both high, and `cmd_done` pulses one cycle after that. A held-off command has no effect and gives no `cmd_done`.
- R13: Op 7 completes with `cmd_done` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_vld | input | 1 | Search request this cycle |
| srch_key | input | KEY_W | Key to look up |
| res_vld | output | 1 | Search result valid |
| res_hit | output | 1 | A visible slot held the key |
| res_idx | output | IDX_W | Lowest matching slot, zero on a miss |
| cmd_vld | input | 1 | Management command present |
| cmd_rdy | output | 1 | Command accepted this cycle (no search) |
| cmd_op | input | 3 | Command code, see R7 to R13 |
| cmd_key | input | KEY_W | Key for learn commands |
| cmd_idx | input | IDX_W | Slot for single-slot skip commands |
| cmd_done | output | 1 | Command completed |
| cmd_full | output | 1 | Learn refused, no free slot |
| cmd_slot | output | IDX_W | Slot written by a learn, else zero |

## Verification
A corrupted flag has no port of its own. It shows up at the next search that touches that slot, as a hit where a miss was due or the reverse, or as the wrong lowest index. It can also show up at the next learn, as a wrong `cmd_slot` or a false `cmd_full`. Errors in the recently-used or pin markers stay hidden until a purge. After the purge they appear as slots that vanish or survive when they should not. The reference model is therefore compared on every cycle, and the directed sequences end each flag change with the searches and learns that expose it. A randomised phase over a tiny key space keeps slots colliding, so stale state is found within a few cycles.

// File: rtl/cam_age_pkg.sv
package cam_age_pkg;

  typedef enum logic [2:0] {
    OP_LEARN        = 3'd0,
    OP_LEARN_PIN    = 3'd1,
    OP_AGE_CLEAR    = 3'd2,
    OP_PURGE        = 3'd3,
    OP_SKIP_SET     = 3'd4,
    OP_SKIP_CLR     = 3'd5,
    OP_SKIP_CLR_ALL = 3'd6,
    OP_NONE         = 3'd7
  } cam_op_e;

endpackage

// File: rtl/cam_first_set.sv
module cam_first_set #(
  parameter int N    = 8,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/cam_key_bank.sv
module cam_key_bank #(
  parameter int KEY_W = 16,
  parameter int DEPTH = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] cmp_key,
  output logic [DEPTH-1:0] eq_vec
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [KEY_W-1:0] key_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        key_q <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        key_q <= wr_key;
      end
    end

    assign eq_vec[g] = (key_q == cmp_key);
  end

endmodule

// File: rtl/cam_flag_bank.sv
module cam_flag_bank #(
  parameter int DEPTH = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IW-1:0]    hit_idx,
  input  logic             learn_en,
  input  logic [IW-1:0]    learn_idx,
  input  logic             learn_pin,
  input  logic             age_clear,
  input  logic             purge,
  input  logic             skip_set,
  input  logic             skip_clr,
  input  logic             skip_clr_all,
  input  logic [IW-1:0]    skip_idx,
  output logic [DEPTH-1:0] empty_q,
  output logic [DEPTH-1:0] skip_q,
  output logic [DEPTH-1:0] pin_q,
  output logic [DEPTH-1:0] age_q
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    logic sel_hit, sel_learn, sel_skip, stale;

    assign sel_hit   = hit_en   && (hit_idx   == IW'(g));
    assign sel_learn = learn_en && (learn_idx == IW'(g));
    assign sel_skip  = (skip_idx == IW'(g));
    assign stale     = !empty_q[g] && !age_q[g] && !pin_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        empty_q[g] <= 1'b1;
        skip_q[g]  <= 1'b0;
        pin_q[g]   <= 1'b0;
        age_q[g]   <= 1'b0;
      end else begin
        if (sel_hit) begin
          age_q[g] <= 1'b1;
        end
        if (sel_learn) begin
          empty_q[g] <= 1'b0;
          pin_q[g]   <= learn_pin;
          age_q[g]   <= 1'b1;
          skip_q[g]  <= 1'b0;
        end
        if (age_clear) begin
          age_q[g] <= 1'b0;
        end
        if (purge && stale) begin
          empty_q[g] <= 1'b1;
        end
        if (skip_set && sel_skip) begin
          skip_q[g] <= 1'b1;
        end
        if ((skip_clr && sel_skip) || skip_clr_all) begin
          skip_q[g] <= 1'b0;
        end
      end
    end
  end

  // R9: an aging sweep leaves no recently-used marker behind
  assert_age_sweep_R9: assert property (@(posedge clk) disable iff (rst)
    age_clear |=> (age_q == '0));

  // R10: after a purge no occupied slot is both unused and unpinned
  assert_purge_stale_R10: assert property (@(posedge clk) disable iff (rst)
    purge |=> ((~empty_q & ~age_q & ~pin_q) == '0));

  // R10: pinned occupied slots survive a purge
  assert_purge_keeps_pin_R10: assert property (@(posedge clk) disable iff (rst)
    purge |=> (($past(~empty_q & pin_q) & empty_q) == '0));

  // R7: the learned slot becomes occupied and recently used
  assert_learn_fills_R7: assert property (@(posedge clk) disable iff (rst)
    learn_en |=> (!empty_q[$past(learn_idx)] && age_q[$past(learn_idx)]));

  // R11: a single-slot skip set takes effect on the next cycle
  assert_skip_set_R11: assert property (@(posedge clk) disable iff (rst)
    skip_set |=> skip_q[$past(skip_idx)]);

endmodule

// File: rtl/cam_age_table.sv
module cam_age_table
  import cam_age_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int DEPTH = 8,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srch_vld,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_vld,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  input  logic             cmd_vld,
  output logic             cmd_rdy,
  input  logic [2:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_done,
  output logic             cmd_full,
  output logic [IDX_W-1:0] cmd_slot
);

  logic [DEPTH-1:0] eq_vec, match_vec, free_vec;
  logic [DEPTH-1:0] empty_q, skip_q, pin_q, age_q;
  logic             s_found, f_found;
  logic [IDX_W-1:0] s_idx, f_idx;
  logic             cmd_acc, is_learn, learn_go, hit_en;
  cam_op_e          op;

  assign op       = cam_op_e'(cmd_op);
  assign cmd_rdy  = !srch_vld;
  assign cmd_acc  = cmd_vld && !srch_vld;
  assign is_learn = cmd_acc && ((op == OP_LEARN) || (op == OP_LEARN_PIN));

  assign match_vec = eq_vec & ~empty_q & ~skip_q;
  assign free_vec  = empty_q & ~skip_q;

  assign hit_en   = srch_vld && s_found;
  assign learn_go = is_learn && f_found;

  cam_key_bank #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IW(IDX_W)) u_keys (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (learn_go),
    .wr_idx  (f_idx),
    .wr_key  (cmd_key),
    .cmp_key (srch_key),
    .eq_vec  (eq_vec)
  );

  cam_first_set #(.N(DEPTH), .IW(IDX_W)) u_hit_pick (
    .req   (match_vec),
    .found (s_found),
    .idx   (s_idx)
  );

  cam_first_set #(.N(DEPTH), .IW(IDX_W)) u_free_pick (
    .req   (free_vec),
    .found (f_found),
    .idx   (f_idx)
  );

  cam_flag_bank #(.DEPTH(DEPTH), .IW(IDX_W)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .hit_en       (hit_en),
    .hit_idx      (s_idx),
    .learn_en     (learn_go),
    .learn_idx    (f_idx),
    .learn_pin    (op == OP_LEARN_PIN),
    .age_clear    (cmd_acc && (op == OP_AGE_CLEAR)),
    .purge        (cmd_acc && (op == OP_PURGE)),
    .skip_set     (cmd_acc && (op == OP_SKIP_SET)),
    .skip_clr     (cmd_acc && (op == OP_SKIP_CLR)),
    .skip_clr_all (cmd_acc && (op == OP_SKIP_CLR_ALL)),
    .skip_idx     (cmd_idx),
    .empty_q      (empty_q),
    .skip_q       (skip_q),
    .pin_q        (pin_q),
    .age_q        (age_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_idx  <= '0;
      cmd_done <= 1'b0;
      cmd_full <= 1'b0;
      cmd_slot <= '0;
    end else begin
      res_vld  <= srch_vld;
      res_hit  <= hit_en;
      res_idx  <= hit_en ? s_idx : '0;
      cmd_done <= cmd_acc;
      cmd_full <= is_learn && !f_found;
      cmd_slot <= learn_go ? f_idx : '0;
    end
  end

  // R2: a search produces a result exactly one cycle later
  assert_search_latency_R2: assert property (@(posedge clk) disable iff (rst)
    srch_vld |=> res_vld);

  // R2: no hit is ever reported without a valid result
  assert_idle_result_R2: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (!res_hit && (res_idx == '0)));

  // R3: a reported slot is occupied and visible
  assert_hit_visible_R3: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (!empty_q[res_idx] && !skip_q[res_idx]));

  // R6: the reported slot carries a fresh recently-used marker
  assert_hit_refresh_R6: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> age_q[res_idx]);

  // R8: a refused learn leaves occupancy untouched
  assert_full_nochange_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && cmd_full) |-> (empty_q == $past(empty_q)));

  // R12: a command held off by a search never completes
  assert_stall_R12: assert property (@(posedge clk) disable iff (rst)
    (srch_vld && cmd_vld) |=> !cmd_done);

endmodule

// File: tb/tb_cam_age_table.sv
module tb_cam_age_table;

  localparam int KEY_W = 16;
  localparam int DEPTH = 8;
  localparam int IW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             srch_vld = 1'b0;
  logic [KEY_W-1:0] srch_key = '0;
  logic             res_vld, res_hit;
  logic [IW-1:0]    res_idx;
  logic             cmd_vld = 1'b0;
  logic             cmd_rdy;
  logic [2:0]       cmd_op = 3'd7;
  logic [KEY_W-1:0] cmd_key = '0;
  logic [IW-1:0]    cmd_idx = '0;
  logic             cmd_done, cmd_full;
  logic [IW-1:0]    cmd_slot;

  always #5 clk = ~clk;

  cam_age_table #(.KEY_W(KEY_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .srch_vld(srch_vld), .srch_key(srch_key),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx),
    .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy), .cmd_op(cmd_op),
    .cmd_key(cmd_key), .cmd_idx(cmd_idx),
    .cmd_done(cmd_done), .cmd_full(cmd_full), .cmd_slot(cmd_slot)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;
  bit    comparing = 1'b0;
  string cur_req  = "R1";

  // behavioural reference model
  logic [KEY_W-1:0] m_key [DEPTH];
  bit m_emp [DEPTH];
  bit m_skp [DEPTH];
  bit m_pin [DEPTH];
  bit m_age [DEPTH];
  bit e_rv, e_rh, e_cd, e_cf;
  int e_ri, e_cs;
  int m_hit, m_free;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_key[i] = '0; m_emp[i] = 1; m_skp[i] = 0; m_pin[i] = 0; m_age[i] = 0;
      end
      e_rv = 0; e_rh = 0; e_ri = 0; e_cd = 0; e_cf = 0; e_cs = 0;
    end else begin
      m_hit = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_hit < 0 && !m_emp[i] && !m_skp[i] && m_key[i] == srch_key) m_hit = i;
      e_rv = srch_vld;
      e_rh = srch_vld && (m_hit >= 0);
      e_ri = e_rh ? m_hit : 0;
      if (e_rh) m_age[m_hit] = 1;
      e_cd = 0; e_cf = 0; e_cs = 0;
      if (cmd_vld && !srch_vld) begin
        e_cd = 1;
        case (cmd_op)
          3'd0, 3'd1: begin
            m_free = -1;
            for (int i = 0; i < DEPTH; i++)
              if (m_free < 0 && m_emp[i] && !m_skp[i]) m_free = i;
            if (m_free < 0) e_cf = 1;
            else begin
              m_key[m_free] = cmd_key; m_emp[m_free] = 0;
              m_pin[m_free] = (cmd_op == 3'd1); m_age[m_free] = 1;
              e_cs = m_free;
            end
          end
          3'd2: for (int i = 0; i < DEPTH; i++) m_age[i] = 0;
          3'd3: for (int i = 0; i < DEPTH; i++)
                  if (!m_emp[i] && !m_age[i] && !m_pin[i]) m_emp[i] = 1;
          3'd4: m_skp[cmd_idx] = 1;
          3'd5: m_skp[cmd_idx] = 0;
          3'd6: for (int i = 0; i < DEPTH; i++) m_skp[i] = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      chk("res_vld",  res_vld,  e_rv);
      chk("res_hit",  res_hit,  e_rh);
      chk("res_idx",  res_idx,  e_ri);
      chk("cmd_done", cmd_done, e_cd);
      chk("cmd_full", cmd_full, e_cf);
      chk("cmd_slot", cmd_slot, e_cs);
      chk("cmd_rdy",  cmd_rdy,  !srch_vld);
    end
  end

  task automatic step(input bit sv, input int sk, input bit cv, input int op,
                      input int ck, input int ci);
    @(negedge clk); #1;
    srch_vld = sv; srch_key = KEY_W'(sk);
    cmd_vld = cv; cmd_op = 3'(op); cmd_key = KEY_W'(ck); cmd_idx = IW'(ci);
  endtask

  task automatic look(input int k);           step(1, k, 0, 7, 0, 0); endtask
  task automatic cmd(input int op, input int k, input int i); step(0, 0, 1, op, k, i); endtask
  task automatic idle();                      step(0, 0, 0, 7, 0, 0); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst = 0;
    comparing = 1;
    // R1: idle outputs after reset; R3: reset slots hold key 0 but are free
    cur_req = "R1"; idle(); idle();
    cur_req = "R3"; look(0); look(16'h11); idle();
    // R7: learn three ordinary slots and one pinned slot
    cur_req = "R7";
    cmd(0, 16'h11, 0); cmd(0, 16'h22, 0); cmd(0, 16'h33, 0); cmd(1, 16'h44, 0); idle();
    cur_req = "R2"; look(16'h22); idle(); look(16'h44); look(16'h99); idle();
    // R5: duplicate key lands in slot 4, lowest copy reported
    cur_req = "R5"; cmd(0, 16'h11, 0); look(16'h11); idle();
    // R4: skipping slot 0 exposes slot 4, clearing restores slot 0
    cur_req = "R4"; cmd(4, 0, 0); look(16'h11); cmd(4, 0, 4); look(16'h11);
    cmd(5, 0, 0); look(16'h11); cmd(6, 0, 0); look(16'h11); idle();
    // R11: a skipped free slot is passed over by learning
    cur_req = "R11"; cmd(4, 0, 5); cmd(0, 16'h55, 0); look(16'h55); idle();
    // R9, R6, R10: sweep, refresh one slot, purge
    cur_req = "R9"; cmd(2, 0, 0); idle();
    cur_req = "R6"; look(16'h22); idle();
    cur_req = "R10"; cmd(3, 0, 0); idle();
    look(16'h11); look(16'h22); look(16'h33); look(16'h44); look(16'h55); idle();
    // R8: fill remaining free slots then overflow
    cur_req = "R8";
    cmd(0, 16'h60, 0); cmd(0, 16'h61, 0); cmd(0, 16'h62, 0); cmd(0, 16'h63, 0);
    cmd(0, 16'h64, 0); cmd(0, 16'h65, 0); cmd(1, 16'h66, 0); look(16'h65); look(16'h66);
    cur_req = "R11"; cmd(5, 0, 5); cmd(0, 16'h67, 0); look(16'h67); idle();
    // R13: unused op has no effect
    cur_req = "R13"; cmd(7, 16'h11, 2); look(16'h67); look(16'h22); idle();
    // R12: a command alongside a search is held off
    cur_req = "R12"; cmd(2, 0, 0); cmd(3, 0, 0);
    step(1, 16'h22, 1, 4, 0, 1); look(16'h22); idle();
    // random phase over a tiny key space
    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 5), $urandom_range(0, DEPTH - 1));
    end
    idle(); idle();
    @(negedge clk);
    comparing = 0;
    finished = 1;
    summary();
    $finish;
  end

endmodule